// File: doc/BRIEF.md
# UART character framer

This block turns bytes into asynchronous serial characters and back again. The format of each character is set by a small group of line-control inputs. These give a data length of five to eight bits, one or two stop bits (one and a half at five bits), and a parity bit that can be off, even, odd or held at a fixed level. A break input forces the outgoing line low. The block has no baud generator. It advances on a one-cycle `tick` pulse that the surrounding logic supplies at sixteen times the bit rate.

The transmit side has a one-byte holding register that feeds a shift register. The block reports separately that the holding register is free and that the whole transmitter is idle. The receive side finds a start edge and confirms it at the middle of the bit. It then samples every following bit at its centre and places the character in a receive register. Data-ready, overrun, parity, framing and break conditions appear as flags. A pulse on `rx_rd` retires data-ready. A pulse on `stat_rd` clears the four error flags, which hold their value until then.

Top module: `uart_framer`

## Requirements
- R1: Characters travel least significant bit first after a low start bit. The `wl` input selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of a transmitted byte are not sent. The received byte is right-aligned in `rx_data`, with its upper bits zero.
- R2: With `stop2` low there is one high stop bit. With `stop2` high there are two, or one and a half when `wl` is 0. For back-to-back characters, the time from one start edge to the next is 16 ticks per bit in total.
- R3: With `par_en` high and `par_stick` low, a parity bit follows the data. Its value gives even parity when `par_even` is high and odd parity when it is low. A received parity bit that does not match sets `parity_err`.
- R4: With `par_en` and `par_stick` both high, the parity bit is fixed at 0 when `par_even` is high and at 1 when it is low. The sent bit and the checked bit both use this value.
- R5: While `brk` is high, `sout` is low from the next clock onward.
- R6: A `tx_valid` pulse loads `tx_data` into the holding register only when `thr_empty` is high. A pulse while the register is full is ignored. `tx_empty` is high only when both the holding register and the shifter are idle.
- R7: A completed character sets `data_ready` and updates `rx_data`. An `rx_rd` pulse clears `data_ready`.
- R8: A character that completes while `data_ready` is still high sets `overrun` and is discarded, so `rx_data` keeps the older character.
- R9: A first stop bit sampled low sets `frame_err`. The character is still delivered.
- R10: A character whose bits, including parity and stop, all sample low sets `brk_det` and `frame_err` and delivers 0. The receiver then waits for the line to go high before it looks for a new start bit.
- R11: `overrun`, `parity_err`, `frame_err` and `brk_det` stay set until a `stat_rd` pulse clears them. A new event in the same cycle as the pulse wins.
- R12: The receiver samples each bit at the middle of its 16 ticks. A start bit that is high again at its midpoint is dropped, and no character results.
- R13: After reset `sout` is high, `thr_empty` and `tx_empty` are high, and `data_ready` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wl | input | 2 | Data length code (0..3 for 5..8 bits) |
| stop2 | input | 1 | Long stop period select |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity / fixed-0 select |
| par_stick | input | 1 | Fixed parity level |
| brk | input | 1 | Force serial output low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Load strobe for `tx_data` |
| sin | input | 1 | Serial input line |
| rx_rd | input | 1 | Receive register read, clears data-ready |
| stat_rd | input | 1 | Status read, clears error flags |
| sout | output | 1 | Serial output line |
| rx_data | output | 8 | Last accepted received byte |
| data_ready | output | 1 | Received byte waiting |
| thr_empty | output | 1 | Holding register free |
| tx_empty | output | 1 | Transmitter fully idle |
| overrun | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity error flag |
| frame_err | output | 1 | Sticky framing error flag |
| brk_det | output | 1 | Sticky break flag |

## Verification
The hardest case to reach is a break that lasts longer than one character. The receiver must report the break once and then stay quiet until the line rises. A receiver that re-arms at once would build a second all-zero character and raise overrun. The stimulus holds `sin` low for about two character times and retires `data_ready` and the flags while the line is still low. It then releases the line and checks that no further character or overrun appears. Stop-length checks need characters with no internal falling edge, such as all ones with no low parity bit. The time between start edges then measures the frame length exactly.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

    localparam int MAX_W = 8;

    typedef enum logic [1:0] {
        WL5 = 2'd0,
        WL6 = 2'd1,
        WL7 = 2'd2,
        WL8 = 2'd3
    } wlen_e;

    typedef struct packed {
        wlen_e wl;
        logic  stop2;
        logic  par_en;
        logic  par_even;
        logic  par_stick;
    } lcr_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP,
        PH_HOLD
    } phase_e;

    function automatic logic [3:0] nbits(input wlen_e wl);
        return {2'b00, wl} + 4'd5;
    endfunction

    function automatic logic [MAX_W-1:0] keep_bits(input logic [MAX_W-1:0] d, input wlen_e wl);
        return d & (8'hFF >> (2'd3 - wl));
    endfunction

    function automatic logic par_bit(input logic stick, input logic even,
                                     input logic [MAX_W-1:0] d);
        if (stick) return ~even;
        return even ? ^d : ~^d;
    endfunction

    function automatic int stop_ticks(input lcr_t c, input int ovs);
        if (!c.stop2) return ovs;
        if (c.wl == WL5) return ovs + ovs / 2;
        return 2 * ovs;
    endfunction

endpackage

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
    import uart_fmt_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  lcr_t             lcr,
    input  logic             brk,
    input  logic             wr,
    input  logic [MAX_W-1:0] wr_data,
    output logic             sout,
    output logic             thr_empty,
    output logic             tx_empty
);
    localparam int CW = $clog2(2 * OVS) + 1;

    logic [MAX_W-1:0] hold_q, sh_q;
    logic             hold_v;
    lcr_t             cfg_q;
    phase_e           ph;
    logic [CW-1:0]    cnt;
    logic [3:0]       left_q;
    logic             par_q, line_q, sout_q;
    logic             bit_end, stop_end;
    logic [MAX_W-1:0] hold_kept;

    assign bit_end   = (cnt == CW'(OVS - 1));
    assign stop_end  = (cnt == CW'(stop_ticks(cfg_q, OVS) - 1));
    assign hold_kept = keep_bits(hold_q, lcr.wl);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            hold_v <= 1'b0;
            sh_q   <= '0;
            cfg_q  <= '0;
            ph     <= PH_IDLE;
            cnt    <= '0;
            left_q <= '0;
            par_q  <= 1'b0;
            line_q <= 1'b1;
            sout_q <= 1'b1;
        end else begin
            if (wr && !hold_v) begin
                hold_q <= wr_data;
                hold_v <= 1'b1;
            end
            if (tick) begin
                unique case (ph)
                    PH_IDLE: begin
                        if (hold_v) begin
                            sh_q   <= hold_kept;
                            cfg_q  <= lcr;
                            par_q  <= par_bit(lcr.par_stick, lcr.par_even, hold_kept);
                            hold_v <= 1'b0;
                            line_q <= 1'b0;
                            cnt    <= '0;
                            ph     <= PH_START;
                        end
                    end
                    PH_START: begin
                        if (bit_end) begin
                            cnt    <= '0;
                            line_q <= sh_q[0];
                            sh_q   <= sh_q >> 1;
                            left_q <= nbits(cfg_q.wl) - 4'd1;
                            ph     <= PH_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (bit_end) begin
                            cnt <= '0;
                            if (left_q == 4'd0) begin
                                line_q <= cfg_q.par_en ? par_q : 1'b1;
                                ph     <= cfg_q.par_en ? PH_PAR : PH_STOP;
                            end else begin
                                line_q <= sh_q[0];
                                sh_q   <= sh_q >> 1;
                                left_q <= left_q - 4'd1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_PAR: begin
                        if (bit_end) begin
                            cnt    <= '0;
                            line_q <= 1'b1;
                            ph     <= PH_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (stop_end) begin
                            cnt <= '0;
                            if (hold_v) begin
                                sh_q   <= hold_kept;
                                cfg_q  <= lcr;
                                par_q  <= par_bit(lcr.par_stick, lcr.par_even, hold_kept);
                                hold_v <= 1'b0;
                                line_q <= 1'b0;
                                ph     <= PH_START;
                            end else begin
                                ph <= PH_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
            sout_q <= brk ? 1'b0 : line_q;
        end
    end

    assign sout      = sout_q;
    assign thr_empty = !hold_v;
    assign tx_empty  = !hold_v && (ph == PH_IDLE);

endmodule

// File: rtl/uart_fmt_rx.sv
module uart_fmt_rx
    import uart_fmt_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sin,
    input  wlen_e            wl,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             par_stick,
    output logic             done,
    output logic [MAX_W-1:0] data,
    output logic             pe,
    output logic             fe,
    output logic             bi
);
    localparam int CW = $clog2(OVS) + 1;

    logic [1:0]       sync_q;
    logic             s_in;
    phase_e           ph;
    logic [CW-1:0]    cnt;
    logic [3:0]       left_q;
    logic [MAX_W-1:0] sh_q;
    wlen_e            wl_q;
    logic             pen_q, peven_q, pstick_q;
    logic             par_rx, zero_q;
    logic             bit_end, mid_start;
    logic [MAX_W-1:0] char_w;

    assign s_in      = sync_q[1];
    assign bit_end   = (cnt == CW'(OVS - 1));
    assign mid_start = (cnt == CW'(OVS / 2 - 1));
    assign char_w    = sh_q >> (4'd8 - nbits(wl_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= 2'b11;
            ph       <= PH_IDLE;
            cnt      <= '0;
            left_q   <= '0;
            sh_q     <= '0;
            wl_q     <= WL8;
            pen_q    <= 1'b0;
            peven_q  <= 1'b0;
            pstick_q <= 1'b0;
            par_rx   <= 1'b0;
            zero_q   <= 1'b0;
            done     <= 1'b0;
            data     <= '0;
            pe       <= 1'b0;
            fe       <= 1'b0;
            bi       <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], sin};
            done   <= 1'b0;
            if (ph == PH_HOLD) begin
                if (s_in) ph <= PH_IDLE;
            end else if (tick) begin
                unique case (ph)
                    PH_IDLE: begin
                        if (!s_in) begin
                            cnt      <= '0;
                            wl_q     <= wl;
                            pen_q    <= par_en;
                            peven_q  <= par_even;
                            pstick_q <= par_stick;
                            ph       <= PH_START;
                        end
                    end
                    PH_START: begin
                        if (mid_start) begin
                            cnt <= '0;
                            if (s_in) begin
                                ph <= PH_IDLE;
                            end else begin
                                sh_q   <= '0;
                                zero_q <= 1'b1;
                                left_q <= nbits(wl_q) - 4'd1;
                                ph     <= PH_DATA;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (bit_end) begin
                            cnt    <= '0;
                            sh_q   <= {s_in, sh_q[MAX_W-1:1]};
                            zero_q <= zero_q & !s_in;
                            if (left_q == 4'd0) ph <= pen_q ? PH_PAR : PH_STOP;
                            else                left_q <= left_q - 4'd1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_PAR: begin
                        if (bit_end) begin
                            cnt    <= '0;
                            par_rx <= s_in;
                            zero_q <= zero_q & !s_in;
                            ph     <= PH_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (bit_end) begin
                            cnt  <= '0;
                            done <= 1'b1;
                            data <= char_w;
                            pe   <= pen_q && (par_rx != par_bit(pstick_q, peven_q, char_w));
                            fe   <= !s_in;
                            bi   <= zero_q && !s_in;
                            ph   <= s_in ? PH_IDLE : PH_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_fmt_stat.sv
module uart_fmt_stat
    import uart_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic [MAX_W-1:0] data,
    input  logic             pe_i,
    input  logic             fe_i,
    input  logic             bi_i,
    input  logic             rx_rd,
    input  logic             stat_rd,
    output logic [MAX_W-1:0] rx_data,
    output logic             data_ready,
    output logic             overrun,
    output logic             parity_err,
    output logic             frame_err,
    output logic             brk_det
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            overrun    <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            brk_det    <= 1'b0;
        end else begin
            if (rx_rd) data_ready <= 1'b0;
            if (stat_rd) begin
                overrun    <= 1'b0;
                parity_err <= 1'b0;
                frame_err  <= 1'b0;
                brk_det    <= 1'b0;
            end
            if (done) begin
                if (data_ready) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data    <= data;
                    data_ready <= 1'b1;
                end
                if (pe_i) parity_err <= 1'b1;
                if (fe_i) frame_err  <= 1'b1;
                if (bi_i) brk_det    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_framer.sv
module uart_framer
    import uart_fmt_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] wl,
    input  logic       stop2,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       brk,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    input  logic       sin,
    input  logic       rx_rd,
    input  logic       stat_rd,
    output logic       sout,
    output logic [7:0] rx_data,
    output logic       data_ready,
    output logic       thr_empty,
    output logic       tx_empty,
    output logic       overrun,
    output logic       parity_err,
    output logic       frame_err,
    output logic       brk_det
);
    lcr_t             lcr;
    logic             rx_done, rx_pe, rx_fe, rx_bi;
    logic [MAX_W-1:0] rx_byte;

    always_comb begin
        lcr.wl        = wlen_e'(wl);
        lcr.stop2     = stop2;
        lcr.par_en    = par_en;
        lcr.par_even  = par_even;
        lcr.par_stick = par_stick;
    end

    uart_fmt_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .tick(tick), .lcr(lcr), .brk(brk),
        .wr(tx_valid), .wr_data(tx_data),
        .sout(sout), .thr_empty(thr_empty), .tx_empty(tx_empty)
    );

    uart_fmt_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .sin(sin),
        .wl(wlen_e'(wl)), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .done(rx_done), .data(rx_byte), .pe(rx_pe), .fe(rx_fe), .bi(rx_bi)
    );

    uart_fmt_stat u_stat (
        .clk(clk), .rst(rst), .done(rx_done), .data(rx_byte),
        .pe_i(rx_pe), .fe_i(rx_fe), .bi_i(rx_bi),
        .rx_rd(rx_rd), .stat_rd(stat_rd),
        .rx_data(rx_data), .data_ready(data_ready), .overrun(overrun),
        .parity_err(parity_err), .frame_err(frame_err), .brk_det(brk_det)
    );

endmodule

// File: rtl/uart_framer_chk.sv
module uart_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic       brk,
    input logic       tx_valid,
    input logic       stat_rd,
    input logic       sout,
    input logic [7:0] rx_data,
    input logic       thr_empty,
    input logic       tx_empty,
    input logic       overrun,
    input logic       parity_err,
    input logic       frame_err,
    input logic       brk_det
);
    AST_BRK_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        brk |=> !sout);                                              // R5
    AST_IDLE_NEEDS_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> thr_empty);                                     // R6
    AST_ACCEPT_FILLS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && thr_empty) |=> !thr_empty);                     // R6
    AST_OVERRUN_KEEPS_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $stable(rx_data));                        // R8
    AST_BREAK_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_det) |-> frame_err);                               // R10
    AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (rst)
        (parity_err && !stat_rd) |=> parity_err);                    // R11
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !stat_rd) |=> overrun);                          // R11
    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (rst)
        (frame_err && !stat_rd) |=> frame_err);                      // R11
endmodule

bind uart_framer uart_framer_chk u_chk (
    .clk(clk), .rst(rst), .brk(brk), .tx_valid(tx_valid), .stat_rd(stat_rd),
    .sout(sout), .rx_data(rx_data), .thr_empty(thr_empty), .tx_empty(tx_empty),
    .overrun(overrun), .parity_err(parity_err), .frame_err(frame_err), .brk_det(brk_det)
);

// File: tb/uart_framer_bench.sv
`timescale 1ns/1ps
module uart_framer_bench;
    localparam int BIT_NS = 512;   // 16 ticks x 4 clocks x 8 ns

    logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic [1:0] wl = 2'd3;
    logic       stop2 = 0, par_en = 0, par_even = 0, par_stick = 0, brk = 0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 0, sin = 1'b1, rx_rd = 0, stat_rd = 0;
    logic       sout, data_ready, thr_empty, tx_empty, overrun, parity_err, frame_err, brk_det;
    logic [7:0] rx_data;

    int n_checks = 0, n_fail = 0;

    uart_framer u_uart_framer (
        .clk(clk), .rst(rst), .tick(tick), .wl(wl), .stop2(stop2), .par_en(par_en),
        .par_even(par_even), .par_stick(par_stick), .brk(brk), .tx_data(tx_data),
        .tx_valid(tx_valid), .sin(sin), .rx_rd(rx_rd), .stat_rd(stat_rd), .sout(sout),
        .rx_data(rx_data), .data_ready(data_ready), .thr_empty(thr_empty),
        .tx_empty(tx_empty), .overrun(overrun), .parity_err(parity_err),
        .frame_err(frame_err), .brk_det(brk_det)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick = 1'b1;
            @(posedge clk);
            #1 tick = 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_fmt(input logic [1:0] w, input logic s2, input logic pe,
                           input logic ev, input logic st);
        @(posedge clk); #1;
        wl = w; stop2 = s2; par_en = pe; par_even = ev; par_stick = st;
    endtask

    task automatic pulse_rx_rd();
        @(posedge clk); #1 rx_rd = 1'b1;
        @(posedge clk); #1 rx_rd = 1'b0;
    endtask

    task automatic pulse_stat_rd();
        @(posedge clk); #1 stat_rd = 1'b1;
        @(posedge clk); #1 stat_rd = 1'b0;
    endtask

    task automatic tx_send(input logic [7:0] d);
        while (!thr_empty) begin @(posedge clk); #1; end
        tx_data = d; tx_valid = 1'b1;
        @(posedge clk); #1 tx_valid = 1'b0;
    endtask

    task automatic wait_tx_idle();
        while (!tx_empty) begin @(posedge clk); #1; end
        #(2 * BIT_NS);
    endtask

    // samples one outgoing character at bit centres
    task automatic tx_capture(input int n, input logic pen, output logic [7:0] d,
                              output logic p, output logic stp);
        d = '0;
        @(negedge sout);
        #(BIT_NS / 2 + 2);
        for (int i = 0; i < n; i++) begin
            #(BIT_NS);
            d[i] = sout;
        end
        p = 1'b0;
        if (pen) begin #(BIT_NS); p = sout; end
        #(BIT_NS);
        stp = sout;
    endtask

    task automatic rx_frame(input int n, input logic [7:0] d, input logic pen,
                            input logic pb, input logic stp);
        @(posedge clk); #3;
        sin = 1'b0; #(BIT_NS);
        for (int i = 0; i < n; i++) begin sin = d[i]; #(BIT_NS); end
        if (pen) begin sin = pb; #(BIT_NS); end
        sin = stp; #(BIT_NS);
        sin = 1'b1; #200;
    endtask

    task automatic t_reset();
        #3;
        chk("R13 sout", sout, 1); chk("R13 thr_empty", thr_empty, 1);
        chk("R13 tx_empty", tx_empty, 1); chk("R13 data_ready", data_ready, 0);
        chk("R13 flags", {overrun, parity_err, frame_err, brk_det}, 0);
    endtask

    task automatic t_tx_formats();
        logic [7:0] d; logic p, s;
        set_fmt(2'd3, 0, 0, 0, 0);
        fork
            tx_send(8'hA5);
            tx_capture(8, 0, d, p, s);
        join
        chk("R1 tx 8-bit data", d, 8'hA5); chk("R2 tx stop level", s, 1);
        wait_tx_idle();
        set_fmt(2'd0, 0, 1, 1, 0);
        fork
            tx_send(8'hFD);
            tx_capture(5, 1, d, p, s);
        join
        chk("R1 tx 5-bit data", d, 8'h1D); chk("R3 tx even parity", p, 0);
        wait_tx_idle();
        set_fmt(2'd1, 0, 1, 0, 0);
        fork
            tx_send(8'h0B);
            tx_capture(6, 1, d, p, s);
        join
        chk("R1 tx 6-bit data", d, 8'h0B); chk("R3 tx odd parity", p, 0);
        wait_tx_idle();
    endtask

    task automatic t_tx_stick();
        logic [7:0] d; logic p, s;
        set_fmt(2'd3, 0, 1, 1, 1);
        fork
            tx_send(8'h01);
            tx_capture(8, 1, d, p, s);
        join
        chk("R4 tx stick low", p, 0);
        wait_tx_idle();
        set_fmt(2'd3, 0, 1, 0, 1);
        fork
            tx_send(8'h01);
            tx_capture(8, 1, d, p, s);
        join
        chk("R4 tx stick high", p, 1);
        wait_tx_idle();
    endtask

    task automatic measure_gap(input logic [7:0] d, output int gap_ns);
        realtime t1, t2;
        fork
            tx_send(d);
            begin @(negedge sout); t1 = $realtime; end
        join
        tx_send(d);
        @(negedge sout); t2 = $realtime;
        gap_ns = int'(t2 - t1);
        wait_tx_idle();
    endtask

    task automatic t_stop_len();
        int g;
        set_fmt(2'd3, 0, 0, 0, 0); measure_gap(8'hFF, g);
        chk("R2 one stop, 10 bits", g, 10 * BIT_NS);
        set_fmt(2'd3, 1, 0, 0, 0); measure_gap(8'hFF, g);
        chk("R2 two stop, 11 bits", g, 11 * BIT_NS);
        set_fmt(2'd0, 1, 0, 0, 0); measure_gap(8'h1F, g);
        chk("R2 one and a half stop, 7.5 bits", g, 15 * BIT_NS / 2);
    endtask

    task automatic t_hold_ignore();
        logic [7:0] d; logic p, s;
        set_fmt(2'd3, 0, 0, 0, 0);
        tx_send(8'hFF);
        tx_send(8'h22);
        tx_data = 8'h33; tx_valid = 1'b1;
        @(posedge clk); #1 tx_valid = 1'b0;
        chk("R6 holding full", thr_empty, 0);
        tx_capture(8, 0, d, p, s);
        chk("R6 second byte sent", d, 8'h22);
        #(BIT_NS);
        chk("R6 write while full ignored", tx_empty, 1);
        chk("R6 line idle", sout, 1);
    endtask

    task automatic t_tx_break();
        @(posedge clk); #1 brk = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #(BIT_NS / 2);
            chk("R5 break holds line low", sout, 0);
        end
        @(posedge clk); #1 brk = 1'b0;
        #40;
        chk("R5 line back high", sout, 1);
    endtask

    task automatic t_rx_basic();
        set_fmt(2'd3, 0, 0, 0, 0);
        rx_frame(8, 8'h5A, 0, 0, 1);
        chk("R7 data_ready set", data_ready, 1); chk("R7 rx byte", rx_data, 8'h5A);
        pulse_rx_rd(); #3;
        chk("R7 data_ready cleared", data_ready, 0);
        set_fmt(2'd1, 0, 0, 0, 0);
        rx_frame(6, 8'hED, 0, 0, 1);
        chk("R1 rx 6-bit right aligned", rx_data, 8'h2D);
        pulse_rx_rd();
    endtask

    task automatic t_rx_parity();
        set_fmt(2'd3, 0, 1, 1, 0);
        rx_frame(8, 8'h03, 1, 0, 1);
        chk("R3 good even parity", parity_err, 0);
        pulse_rx_rd();
        rx_frame(8, 8'h03, 1, 1, 1);
        chk("R3 bad parity flagged", parity_err, 1);
        pulse_rx_rd();
        rx_frame(8, 8'h07, 1, 1, 1);
        chk("R11 parity error sticky", parity_err, 1);
        pulse_rx_rd(); pulse_stat_rd(); #3;
        chk("R11 status read clears", parity_err, 0);
        set_fmt(2'd3, 0, 1, 1, 1);
        rx_frame(8, 8'h01, 1, 0, 1);
        chk("R4 rx stick 0 accepted", parity_err, 0);
        pulse_rx_rd();
        rx_frame(8, 8'h00, 1, 1, 1);
        chk("R4 rx stick mismatch", parity_err, 1);
        pulse_rx_rd(); pulse_stat_rd();
    endtask

    task automatic t_rx_frame_err();
        set_fmt(2'd3, 0, 0, 0, 0);
        rx_frame(8, 8'h81, 0, 0, 0);
        chk("R9 framing error", frame_err, 1); chk("R9 no break", brk_det, 0);
        chk("R9 byte delivered", rx_data, 8'h81);
        pulse_rx_rd(); pulse_stat_rd();
    endtask

    task automatic t_rx_break();
        set_fmt(2'd3, 0, 0, 0, 0);
        @(posedge clk); #3 sin = 1'b0;
        #(12 * BIT_NS);
        chk("R10 break flag", brk_det, 1); chk("R10 frame flag", frame_err, 1);
        chk("R10 zero byte", rx_data, 0); chk("R10 data ready", data_ready, 1);
        pulse_rx_rd(); pulse_stat_rd();
        #(12 * BIT_NS);
        sin = 1'b1;
        #(12 * BIT_NS);
        chk("R10 no repeat while low", data_ready, 0);
        chk("R10 no overrun", overrun, 0);
    endtask

    task automatic t_overrun();
        set_fmt(2'd3, 0, 0, 0, 0);
        rx_frame(8, 8'h11, 0, 0, 1);
        rx_frame(8, 8'h22, 0, 0, 1);
        chk("R8 overrun set", overrun, 1); chk("R8 older byte kept", rx_data, 8'h11);
        pulse_stat_rd(); #3;
        chk("R11 overrun cleared", overrun, 0);
        pulse_rx_rd();
    endtask

    task automatic t_start_reject();
        @(posedge clk); #3 sin = 1'b0;
        #96 sin = 1'b1;
        #(12 * BIT_NS);
        chk("R12 glitch gives no byte", data_ready, 0);
        chk("R12 glitch gives no error", frame_err, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_tx_formats();
        t_tx_stick();
        t_stop_len();
        t_hold_ignore();
        t_tx_break();
        t_rx_basic();
        t_rx_parity();
        t_rx_frame_err();
        t_rx_break();
        t_overrun();
        t_start_reject();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_200_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule